// File: doc/BRIEF.md
# Fixed-Length Serial Message Transmitter

This block turns words loaded by a host into one serial message whose length is set in bytes. The host pushes 32-bit words into an internal transmit FIFO through a write port that also carries a word address. A byte length and an almost-empty level sit on configuration inputs and are held steady while a message is in flight. Once a message starts, the words are serialized onto a clock/data/strobe line toward a far-end receiver that signals its readiness on a ready input. The pace of the line is set by a single-cycle rate enable coming from an external divider.

A message starts in one of two ways. The first is an explicit start pulse. The second is automatic: a host write lands on the word address that holds the final byte of the message. Short control messages can therefore be loaded and sent with no extra command. For messages longer than the FIFO, the host keeps writing while the message runs, and an almost-empty interrupt tells it when to refill. When the byte count ends partway through a word, only the needed bytes of that word are sent.

Top module: `msg_ser_tx`

## Requirements
- R1: While reset is held and right after it is released, ser_stb, ser_clk, ser_dat, busy, done, underrun and ae_irq are all 0.
- R2: Words are sent in the order they were written to the FIFO, and each word is sent from bit 31 down to bit 0.
- R3: A message carries exactly 8 × len_bytes bits. When len_bytes is not a multiple of 4, the low-order bytes of the last word are dropped, and the next message begins with the next word in the FIFO.
- R4: A FIFO write starts a message when the block is idle, ser_rdy is 1, len_bytes is nonzero, and wr_addr equals ceil(len_bytes/4) − 1. A write to any other address starts nothing.
- R5: A start pulse is accepted only when the block is idle, ser_rdy is 1 and len_bytes is nonzero. A start pulse while ser_rdy is 0 or while a message is running has no effect.
- R6: ser_stb stays 1 from the first bit to the last. ser_clk is 0 whenever ser_stb is 0. Each bit gets one rising and one falling ser_clk edge, each on a rate_en cycle. ser_dat changes only together with a falling ser_clk.
- R7: done is 1 for exactly one cycle, in the cycle where ser_stb falls after the final bit.
- R8: If the next word is needed while the FIFO is empty, underrun goes to 1, ser_stb drops, the message ends without done, and the FIFO is never popped while empty. underrun stays 1 until the next accepted start clears it.
- R9: ae_irq is 1 exactly when a message is running and the FIFO holds ae_level words or fewer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe; pushes wr_data unless the FIFO is full |
| wr_addr | input | 14 | Word address of the write, used only for the auto-start match |
| wr_data | input | 32 | Word pushed into the FIFO |
| len_bytes | input | 16 | Message length in bytes, 1 to 65535 |
| ae_level | input | 5 | Almost-empty level in words |
| start | input | 1 | Explicit start request |
| rate_en | input | 1 | Line rate enable, one cycle wide |
| ser_rdy | input | 1 | Far-end ready |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_stb | output | 1 | Message strobe |
| busy | output | 1 | A message is loading or shifting |
| done | output | 1 | One-cycle pulse after the final bit |
| underrun | output | 1 | Sticky FIFO-starved abort flag |
| ae_irq | output | 1 | Almost-empty interrupt |

## Verification
The assertions assume that len_bytes and ae_level stay constant while a message is running, and that rate_en is a single-cycle pulse. Under those assumptions the framing and done checks depend only on the engine's own tick sequence. The bench changes configuration only when busy has gone low, and it drives rate_en as one pulse every three cycles from a free-running counter. This keeps both assumptions true for every message, including the underrun abort and the attempt to restart in the middle of a message.

// File: rtl/msg_ser_pkg.sv
package msg_ser_pkg;
  localparam int LEN_W  = 16;
  localparam int WORD_W = 32;
  localparam int BPW    = WORD_W / 8;
  localparam int BPW_SH = $clog2(BPW);
  localparam int ADDR_W = LEN_W - BPW_SH;
  localparam int BITS_W = LEN_W + 3;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT
  } tx_state_e;

  // word address that holds the final byte of a message
  function automatic logic [ADDR_W-1:0] eom_addr(input logic [LEN_W-1:0] n);
    logic [LEN_W:0] words;
    words = ({1'b0, n} + (LEN_W+1)'(BPW - 1)) >> BPW_SH;
    return ADDR_W'(words - (LEN_W+1)'(1));
  endfunction

  // number of serial bits in a message of n bytes
  function automatic logic [BITS_W-1:0] msg_bits(input logic [LEN_W-1:0] n);
    return {n, 3'b000};
  endfunction
endpackage

// File: rtl/msg_tx_fifo.sv
module msg_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt;
  logic             push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LVL_W'(DEPTH));
  assign level   = cnt;
  assign rdata   = mem[rd_ptr];
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LVL_W'(DEPTH));
endmodule

// File: rtl/msg_tx_engine.sv
module msg_tx_engine
  import msg_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic              rate_en,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              pop,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_stb,
  output logic              busy,
  output logic              done,
  output logic              underrun
);
  tx_state_e         state;
  logic [WORD_W-1:0] shreg;
  logic [BITS_W-1:0] bits_left;
  logic [IDX_W-1:0]  bit_idx;
  logic              sclk, stb, done_q, urun;

  // named internal events
  logic load_ok, fall_tick, last_bit, word_end, starve;

  always_comb begin
    load_ok   = (state == ST_LOAD) && !fifo_empty;
    fall_tick = (state == ST_SHIFT) && rate_en && sclk;
    last_bit  = fall_tick && (bits_left == BITS_W'(1));
    word_end  = fall_tick && !last_bit && (bit_idx == IDX_W'(WORD_W - 1));
    starve    = ((state == ST_LOAD) && fifo_empty) || (word_end && fifo_empty);
    pop       = load_ok || (word_end && !fifo_empty);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      bit_idx   <= '0;
      sclk      <= 1'b0;
      stb       <= 1'b0;
      done_q    <= 1'b0;
      urun      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            state     <= ST_LOAD;
            bits_left <= msg_bits(len_bytes);
            urun      <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (starve) begin
            urun  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            shreg   <= fifo_rdata;
            bit_idx <= '0;
            sclk    <= 1'b0;
            stb     <= 1'b1;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rate_en) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (last_bit) begin
                stb    <= 1'b0;
                done_q <= 1'b1;
                state  <= ST_IDLE;
              end else if (starve) begin
                stb   <= 1'b0;
                urun  <= 1'b1;
                state <= ST_IDLE;
              end else if (word_end) begin
                shreg     <= fifo_rdata;
                bit_idx   <= '0;
                bits_left <= bits_left - 1'b1;
              end else begin
                shreg     <= {shreg[WORD_W-2:0], 1'b0};
                bit_idx   <= bit_idx + 1'b1;
                bits_left <= bits_left - 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk  = sclk;
  assign ser_stb  = stb;
  assign ser_dat  = stb && shreg[WORD_W-1];
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign underrun = urun;

  // R6
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_stb |-> !ser_clk);

  // R6
  dat_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> (!ser_clk || $stable(ser_dat)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_at_stb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_stb && $past(ser_stb)));

  // R8
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !busy && !go) |=> underrun);
endmodule

// File: rtl/msg_ser_tx.sv
module msg_ser_tx
  import msg_ser_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [LVL_W-1:0]  ae_level,
  input  logic              start,
  input  logic              rate_en,
  input  logic              ser_rdy,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_stb,
  output logic              busy,
  output logic              done,
  output logic              underrun,
  output logic              ae_irq
);
  logic              fifo_pop, fifo_empty, fifo_full;
  logic [WORD_W-1:0] fifo_rdata;
  logic [LVL_W-1:0]  fifo_level;

  // named start events
  logic eom_hit, can_start, go;

  always_comb begin
    eom_hit   = wr_en && (wr_addr == eom_addr(len_bytes));
    can_start = !busy && ser_rdy && (len_bytes != '0);
    go        = can_start && (start || eom_hit);
  end

  msg_tx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  msg_tx_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .len_bytes  (len_bytes),
    .rate_en    (rate_en),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .pop        (fifo_pop),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .ser_stb    (ser_stb),
    .busy       (busy),
    .done       (done),
    .underrun   (underrun)
  );

  assign ae_irq = busy && (fifo_level <= ae_level);

  // R5
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !underrun && start) |=> (busy || done || underrun));

  // R9
  full_no_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && (ae_level < LVL_W'(FIFO_DEPTH))) |-> !ae_irq);
endmodule

// File: tb/test_msg_ser_tx.sv
`timescale 1ns/100ps
module test_msg_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] len_bytes = 16'd0;
  logic [4:0]  ae_level = 5'd0;
  logic        start = 1'b0;
  logic        rate_en = 1'b0;
  logic        ser_rdy = 1'b1;
  logic        ser_clk, ser_dat, ser_stb, busy, done, underrun, ae_irq;

  int n_checks = 0;
  int n_err = 0;
  int bits_seen = 0;
  int done_cnt = 0;
  logic prev_sclk = 1'b0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  msg_ser_tx i_msg_ser_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .len_bytes(len_bytes), .ae_level(ae_level), .start(start), .rate_en(rate_en),
    .ser_rdy(ser_rdy), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb),
    .busy(busy), .done(done), .underrun(underrun), .ae_irq(ae_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // rate enable: one pulse every three cycles
  initial begin
    forever begin
      @(negedge clk); rate_en = 1'b0;
      @(negedge clk); rate_en = 1'b0;
      @(negedge clk); rate_en = 1'b1;
    end
  end

  // monitor: pop expected bits at each rising serial clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !prev_sclk) begin
        bits_seen++;
        chk("R6 stb during bit", {31'd0, ser_stb}, 32'd1);
        if (exp_q.size() == 0) chk("R3 extra bit", 32'd1, 32'd0);
        else chk("R2 bit value", {31'd0, ser_dat}, {31'd0, exp_q.pop_front()});
      end
      if (done) done_cnt++;
      prev_sclk = ser_clk;
    end
  end

  // driver: expected bits go into the scoreboard queue
  task automatic expect_bits(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) exp_q.push_back(w[31-i]);
  endtask

  task automatic host_write(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_bits(input int target);
    while (bits_seen < target) @(negedge clk);
  endtask

  initial begin
    #(5 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int d0, base;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 stb", {31'd0, ser_stb}, 0);
    chk("R1 clk", {31'd0, ser_clk}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dat", {31'd0, ser_dat}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done/urun/ae", {29'd0, done, underrun, ae_irq}, 0);

    // R4 auto-start, R3 partial last word: 6 bytes
    len_bytes = 16'd6;
    expect_bits(32'hA5C3_0F81, 32);
    expect_bits(32'h1234_5678, 16);
    host_write(14'd0, 32'hA5C3_0F81);
    chk("R4 no start on addr 0", {31'd0, busy}, 0);
    host_write(14'd1, 32'h1234_5678);
    chk("R4 auto-start at end address", {31'd0, busy}, 1);
    d0 = done_cnt;
    wait_idle();
    chk("R7 one done", done_cnt, d0 + 1);
    chk("R3 all bits sent", exp_q.size(), 0);
    chk("R8 no underrun", {31'd0, underrun}, 0);

    // R3 leftover discarded: 1 byte from next word
    len_bytes = 16'd1;
    expect_bits(32'h9E00_0000, 8);
    host_write(14'd0, 32'h9EFF_FFFF);
    chk("R4 auto-start len 1", {31'd0, busy}, 1);
    wait_idle();
    chk("R3 single byte", exp_q.size(), 0);

    // R4 mismatch, R5 ready gating and busy ignore: 7 bytes
    len_bytes = 16'd7;
    host_write(14'd0, 32'h0F0F_3C3C);
    host_write(14'd5, 32'hDEAD_BEEF);
    chk("R4 no start on other addr", {31'd0, busy}, 0);
    ser_rdy = 1'b0;
    pulse_start();
    chk("R5 start ignored when not ready", {31'd0, busy}, 0);
    ser_rdy = 1'b1;
    expect_bits(32'h0F0F_3C3C, 32);
    expect_bits(32'hDEAD_BEEF, 24);
    base = bits_seen;
    d0 = done_cnt;
    pulse_start();
    chk("R5 start accepted", {31'd0, busy}, 1);
    wait_bits(base + 5);
    pulse_start();
    wait_idle();
    chk("R5 no restart after busy start", {31'd0, busy}, 0);
    chk("R7 single done", done_cnt, d0 + 1);
    chk("R3 56 bits", bits_seen - base, 56);

    // R8 underrun: 12 bytes, only one word loaded
    len_bytes = 16'd12;
    expect_bits(32'hC001_D00D, 32);
    host_write(14'd0, 32'hC001_D00D);
    d0 = done_cnt;
    pulse_start();
    wait_idle();
    chk("R8 underrun set", {31'd0, underrun}, 1);
    chk("R8 stb dropped", {31'd0, ser_stb}, 0);
    chk("R8 no done", done_cnt, d0);
    chk("R8 32 bits before abort", exp_q.size(), 0);
    len_bytes = 16'd1;
    expect_bits(32'h5A00_0000, 8);
    host_write(14'd0, 32'h5A00_0000);
    chk("R8 cleared by new start", {31'd0, underrun}, 0);
    wait_idle();

    // R9 almost-empty: 20 bytes, level 2
    len_bytes = 16'd20;
    ae_level = 5'd2;
    chk("R9 idle no irq", {31'd0, ae_irq}, 0);
    for (int k = 0; k < 5; k++) begin
      expect_bits(32'h1111_1111 * (k + 1), 32);
    end
    base = bits_seen;
    for (int k = 0; k < 5; k++) host_write(14'(k), 32'h1111_1111 * (k + 1));
    wait_bits(base + 10);
    chk("R9 level 4 no irq", {31'd0, ae_irq}, 0);
    wait_bits(base + 100);
    chk("R9 level 1 irq", {31'd0, ae_irq}, 1);
    wait_idle();
    chk("R9 irq off after message", {31'd0, ae_irq}, 0);
    chk("R2 five words", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule